// File: doc/BRIEF.md
# Two-Level Page Table Refill Walker

This block services a translation miss. It receives a faulting virtual address with its privilege mode and its write and write-test flags. It picks one of four page-table base addresses according to mode and address-space half, then reads the page-table word from physical memory. The entry sits in the left or the right halfword of that word, and the block decodes its two-bit access code from there.

On success the block does two things. It writes the word back to the same address with the age bit of the chosen halfword cleared. It then issues two writes to the translation buffer. One large page covers two small hardware pages, so the even small page maps to an even physical small page and the odd small page to the odd one. When the access is refused, the block returns a one-cycle fault with a compact fault word. It makes no write-back and no translation write in that case.

The memory port carries one request at a time under a req/ack handshake. The translation-buffer write port is a bare write strobe with an index and an entry.

Top module: `pt_refill_walker`

## Requirements
- R1: The read address is the base plus the zero-extended six-bit index `va[16:11]`. The base is chosen by the user flag and by `va[17]`. User with `va[17]`=0 uses `base_user_lo`, user with 1 uses `base_user_hi`, exec with 0 uses `base_exec_lo`, and exec with 1 uses `base_exec_hi`.
- R2: When `va[10]` is 1 the entry is the right halfword (word bits 17:0). When it is 0 the entry is the left halfword (bits 35:18). Inside a halfword, bits 17:16 hold the access code, bit 13 the age bit, bit 12 the cache bit and bits 9:0 the large physical page number.
- R3: Access code 0 gives a fault with access field 0. There is then no write-back and no translation write.
- R4: Codes 1 (read-only) and 2 (read/write/first) are both treated as read-only. A write request with either code gives a fault that carries the code in the access field. A read request with either code installs entries with writable=0.
- R5: Code 3 installs entries with writable=1, for reads and for writes alike.
- R6: A write-test request behaves exactly like a write request. This holds for the access check and for the write flag in the fault word.
- R7: Before the translation writes, the word is written back to the address it was read from. Only the age bit of the selected halfword is cleared; every other bit is unchanged.
- R8: On success exactly two translation writes follow, in consecutive cycles. The first goes to `tlb_vpn = {va[17:10],0}` with physical small page `{lpn,0}`. The second goes to `{va[17:10],1}` with `{lpn,1}`. Both carry the entry `{valid=1, writable, cache, ppn[10:0]}`, with valid as bit 13 and writable as bit 12.
- R9: The fault word is `{user, write, access[1:0], va[17:0]}`, with user as bit 21.
- R10: `done` and `fault` are one-cycle pulses and never high together. A miss is taken only when the block is idle; `miss_valid` during a walk has no effect.
- R11: `mem_req`, `mem_we` and `mem_addr` stay stable from the raising of a request until `mem_ack`. Only one request is outstanding, and `mem_we` is high only for the write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request strobe, taken when idle |
| miss_va | input | 18 | Faulting virtual address |
| miss_user | input | 1 | 1 = user mode, 0 = exec |
| miss_write | input | 1 | Write access |
| miss_wtest | input | 1 | Write-test access |
| base_user_lo | input | 20 | Table base, user low half |
| base_user_hi | input | 20 | Table base, user high half |
| base_exec_lo | input | 20 | Table base, exec low half |
| base_exec_hi | input | 20 | Table base, exec high half |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 20 | Physical word address |
| mem_wdata | output | 36 | Write-back data |
| mem_rdata | input | 36 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Request completion |
| tlb_we | output | 1 | Translation write strobe |
| tlb_user | output | 1 | Mode of the written entry |
| tlb_vpn | output | 9 | Small virtual page index |
| tlb_entry | output | 14 | {valid, writable, cache, ppn[10:0]} |
| done | output | 1 | Refill completed pulse |
| fault | output | 1 | Page fault pulse |
| fault_word | output | 22 | Fault description, valid with fault |

## Verification
A wrong walk state shows at the ports within a few cycles. A missing or repeated memory request, a write strobe during the read, or a third or missing translation write all appear in the same transaction. A bad halfword or base choice shows as a wrong read address or a wrong physical page in the two entries. A bad decode shows either as a fault where a refill was due or as a wrong writable bit. A lost age-bit clear, or a change to the other halfword, appears in the write-back data before `done`.

// File: rtl/pw_pkg.sv
package pw_pkg;

  typedef enum logic [2:0] {
    PW_IDLE,
    PW_READ,
    PW_CHECK,
    PW_WBACK,
    PW_LOAD_EVEN,
    PW_LOAD_ODD,
    PW_DONE,
    PW_FAULT
  } pw_state_e;

  typedef enum logic [1:0] {
    ACC_NONE  = 2'd0,
    ACC_READ  = 2'd1,
    ACC_FIRST = 2'd2,
    ACC_RDWR  = 2'd3
  } pw_access_e;

endpackage

// File: rtl/pw_base_select.sv
module pw_base_select #(
  parameter int IDX_W = 6,
  parameter int PA_W  = 20,
  localparam int HI_W = IDX_W + 2
) (
  input  logic [HI_W-1:0] va_hi,
  input  logic            user,
  input  logic [PA_W-1:0] base_user_lo,
  input  logic [PA_W-1:0] base_user_hi,
  input  logic [PA_W-1:0] base_exec_lo,
  input  logic [PA_W-1:0] base_exec_hi,
  output logic [PA_W-1:0] pt_addr,
  output logic            right_half
);

  logic [PA_W-1:0] base;
  logic [IDX_W-1:0] index;

  assign index      = va_hi[IDX_W:1];
  assign right_half = va_hi[0];

  always_comb begin
    case ({user, va_hi[HI_W-1]})
      2'b10:   base = base_user_lo;
      2'b11:   base = base_user_hi;
      2'b00:   base = base_exec_lo;
      default: base = base_exec_hi;
    endcase
  end

  assign pt_addr = base + {{(PA_W-IDX_W){1'b0}}, index};

endmodule

// File: rtl/pw_entry_decode.sv
module pw_entry_decode import pw_pkg::*; #(
  parameter int WORD_W    = 36,
  parameter int LPN_W     = 10,
  parameter int AGE_BIT   = 13,
  parameter int CACHE_BIT = 12,
  localparam int HALF_W   = WORD_W / 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic              right_half,
  input  logic              wr_req,
  output logic              fault_now,
  output logic [1:0]        acc_field,
  output logic              writable,
  output logic              cache,
  output logic [LPN_W-1:0]  lpn,
  output logic [WORD_W-1:0] wb_word
);

  pw_access_e code;
  logic [WORD_W-1:0] age_mask;

  always_comb begin
    if (right_half) begin
      code  = pw_access_e'(word[HALF_W-1 -: 2]);
      cache = word[CACHE_BIT];
      lpn   = word[LPN_W-1:0];
    end else begin
      code  = pw_access_e'(word[WORD_W-1 -: 2]);
      cache = word[HALF_W+CACHE_BIT];
      lpn   = word[HALF_W +: LPN_W];
    end
  end

  always_comb begin
    age_mask = '0;
    if (right_half) age_mask[AGE_BIT] = 1'b1;
    else            age_mask[HALF_W+AGE_BIT] = 1'b1;
  end

  assign wb_word   = word & ~age_mask;
  assign writable  = (code == ACC_RDWR);
  assign fault_now = (code == ACC_NONE) || ((code != ACC_RDWR) && wr_req);
  assign acc_field = (code == ACC_RDWR) ? 2'd0 : code;

endmodule

// File: rtl/pt_refill_walker.sv
module pt_refill_walker import pw_pkg::*; #(
  parameter int IDX_W     = 6,
  parameter int OFF_W     = 9,
  parameter int PA_W      = 20,
  parameter int WORD_W    = 36,
  parameter int LPN_W     = 10,
  parameter int AGE_BIT   = 13,
  parameter int CACHE_BIT = 12,
  localparam int VA_W     = IDX_W + OFF_W + 3,
  localparam int VPN_W    = VA_W - OFF_W,
  localparam int TLB_W    = LPN_W + 4,
  localparam int FW_W     = VA_W + 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              miss_valid,
  input  logic [VA_W-1:0]   miss_va,
  input  logic              miss_user,
  input  logic              miss_write,
  input  logic              miss_wtest,
  input  logic [PA_W-1:0]   base_user_lo,
  input  logic [PA_W-1:0]   base_user_hi,
  input  logic [PA_W-1:0]   base_exec_lo,
  input  logic [PA_W-1:0]   base_exec_hi,
  output logic              mem_req,
  output logic              mem_we,
  output logic [PA_W-1:0]   mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  input  logic              mem_ack,
  output logic              tlb_we,
  output logic              tlb_user,
  output logic [VPN_W-1:0]  tlb_vpn,
  output logic [TLB_W-1:0]  tlb_entry,
  output logic              done,
  output logic              fault,
  output logic [FW_W-1:0]   fault_word
);

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  pw_state_e         state_q, state_d;
  logic [VA_W-1:0]   va_q;
  logic              user_q, wr_q;
  logic [WORD_W-1:0] word_q;
  logic [FW_W-1:0]   fw_q;

  logic              right_half, fault_now, writable, cache, odd;
  logic [PA_W-1:0]   pt_addr;
  logic [1:0]        acc_field;
  logic [LPN_W-1:0]  lpn;
  logic [WORD_W-1:0] wb_word;

  logic accept_en, word_en, fw_en;

  pw_base_select #(.IDX_W(IDX_W), .PA_W(PA_W)) u_base (
    .va_hi        (va_q[VA_W-1:OFF_W+1]),
    .user         (user_q),
    .base_user_lo (base_user_lo),
    .base_user_hi (base_user_hi),
    .base_exec_lo (base_exec_lo),
    .base_exec_hi (base_exec_hi),
    .pt_addr      (pt_addr),
    .right_half   (right_half)
  );

  pw_entry_decode #(
    .WORD_W(WORD_W), .LPN_W(LPN_W), .AGE_BIT(AGE_BIT), .CACHE_BIT(CACHE_BIT)
  ) u_decode (
    .word       (word_q),
    .right_half (right_half),
    .wr_req     (wr_q),
    .fault_now  (fault_now),
    .acc_field  (acc_field),
    .writable   (writable),
    .cache      (cache),
    .lpn        (lpn),
    .wb_word    (wb_word)
  );

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      PW_IDLE:      if (miss_valid) state_d = PW_READ;
      PW_READ:      if (mem_ack)    state_d = PW_CHECK;
      PW_CHECK:     state_d = fault_now ? PW_FAULT : PW_WBACK;
      PW_WBACK:     if (mem_ack)    state_d = PW_LOAD_EVEN;
      PW_LOAD_EVEN: state_d = PW_LOAD_ODD;
      PW_LOAD_ODD:  state_d = PW_DONE;
      default:      state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= PW_IDLE;
    else             state_q <= state_d;
  end

  assign accept_en = (state_q == PW_IDLE) && miss_valid;
  assign word_en   = (state_q == PW_READ) && mem_ack;
  assign fw_en     = (state_q == PW_CHECK) && fault_now;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      va_q   <= '0;
      user_q <= 1'b0;
      wr_q   <= 1'b0;
    end else if (accept_en) begin
      va_q   <= miss_va;
      user_q <= miss_user;
      wr_q   <= miss_write | miss_wtest;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  word_q <= '0;
    else if (word_en) word_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fw_q <= '0;
    else if (fw_en)  fw_q <= {user_q, wr_q, acc_field, va_q};
  end

  assign mem_req   = (state_q == PW_READ) || (state_q == PW_WBACK);
  assign mem_we    = (state_q == PW_WBACK);
  assign mem_addr  = pt_addr;
  assign mem_wdata = wb_word;

  assign odd       = (state_q == PW_LOAD_ODD);
  assign tlb_we    = (state_q == PW_LOAD_EVEN) || odd;
  assign tlb_user  = user_q;
  assign tlb_vpn   = {va_q[VA_W-1:OFF_W+1], odd};
  assign tlb_entry = {1'b1, writable, cache, lpn, odd};

  assign done       = (state_q == PW_DONE);
  assign fault      = (state_q == PW_FAULT);
  assign fault_word = fw_q;

endmodule

// File: rtl/pw_walk_checker.sv
module pw_walk_checker #(
  parameter int PA_W  = 20,
  parameter int VPN_W = 9,
  parameter int TLB_W = 14
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_req,
  input logic             mem_we,
  input logic             mem_ack,
  input logic [PA_W-1:0]  mem_addr,
  input logic             tlb_we,
  input logic [VPN_W-1:0] tlb_vpn,
  input logic [TLB_W-1:0] tlb_entry,
  input logic             done,
  input logic             fault
);

  logic [PA_W-1:0] rd_addr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                           rd_addr_q <= '0;
    else if (mem_req && !mem_we && mem_ack) rd_addr_q <= mem_addr;
  end

  assert_req_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

  assert_wb_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_addr == rd_addr_q);

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  assert_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fault));

  assert_tlb_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we && !tlb_vpn[0] |=> tlb_we && tlb_vpn[0]);

  assert_tlb_lsb_R8: assert property (@(posedge clk) disable iff (!rst_n)
    tlb_we |-> tlb_entry[TLB_W-1] && (tlb_entry[0] == tlb_vpn[0]));

  assert_fault_clean_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> !tlb_we && !mem_req);

endmodule

bind pt_refill_walker pw_walk_checker #(
  .PA_W(PA_W), .VPN_W(VPN_W), .TLB_W(TLB_W)
) u_walk_checker (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .tlb_we    (tlb_we),
  .tlb_vpn   (tlb_vpn),
  .tlb_entry (tlb_entry),
  .done      (done),
  .fault     (fault)
);

// File: tb/test_pt_refill_walker.sv
`timescale 1ns/1ps
module test_pt_refill_walker;

  localparam logic [19:0] B_UL = 20'h10000;
  localparam logic [19:0] B_UH = 20'h20040;
  localparam logic [19:0] B_EL = 20'h30080;
  localparam logic [19:0] B_EH = 20'h400C0;

  // {va[17:0], user, write, wtest, word[35:0]}
  localparam logic [56:0] VECS [10] = '{
    {{1'b0,6'd5, 1'b1,10'h0A3}, 3'b100, {18'h00000,18'h33155}},
    {{1'b1,6'd63,1'b0,10'h3FF}, 3'b110, {18'h32ABC,18'h3FFFF}},
    {{1'b0,6'd0, 1'b1,10'h200}, 3'b000, {18'h3FFFF,18'h11ACE}},
    {{1'b1,6'd17,1'b0,10'h001}, 3'b000, {18'h22001,18'h00000}},
    {{1'b0,6'd2, 1'b1,10'h155}, 3'b110, {18'h30000,18'h13001}},
    {{1'b1,6'd40,1'b0,10'h2AA}, 3'b010, {18'h23333,18'h30000}},
    {{1'b1,6'd9, 1'b1,10'h000}, 3'b100, {18'h3FFFF,18'h03FFF}},
    {{1'b0,6'd3, 1'b0,10'h3C0}, 3'b001, {18'h12345,18'h3FFFF}},
    {{1'b0,6'd4, 1'b1,10'h111}, 3'b101, {18'h0FFFF,18'h3E3FF}},
    {{1'b0,6'd6, 1'b0,10'h222}, 3'b000, {18'h3F0F0,18'h2FFFF}}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic miss_valid = 1'b0;
  logic [17:0] miss_va = '0;
  logic miss_user = 1'b0, miss_write = 1'b0, miss_wtest = 1'b0;
  logic mem_req, mem_we, mem_ack, tlb_we, tlb_user, done, fault;
  logic [19:0] mem_addr;
  logic [35:0] mem_wdata, mem_rdata;
  logic [8:0]  tlb_vpn;
  logic [13:0] tlb_entry;
  logic [21:0] fault_word;

  logic [35:0] mem_arr [256];
  logic ack_q = 1'b0;

  int n_checks = 0;
  int n_fail = 0;

  int rd_cnt, wb_cnt, tlb_cnt;
  logic [19:0] rd_addr, wb_addr;
  logic [35:0] wb_data;
  logic [8:0]  vpn_log [2];
  logic [13:0] ent_log [2];
  logic        usr_log [2];

  always #5 clk = ~clk;

  pt_refill_walker i_pt_refill_walker (
    .clk(clk), .rst_n(rst_n),
    .miss_valid(miss_valid), .miss_va(miss_va), .miss_user(miss_user),
    .miss_write(miss_write), .miss_wtest(miss_wtest),
    .base_user_lo(B_UL), .base_user_hi(B_UH),
    .base_exec_lo(B_EL), .base_exec_hi(B_EH),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
    .tlb_we(tlb_we), .tlb_user(tlb_user), .tlb_vpn(tlb_vpn),
    .tlb_entry(tlb_entry), .done(done), .fault(fault),
    .fault_word(fault_word)
  );

  // memory model: acknowledges one cycle after a request is seen
  assign mem_ack   = ack_q;
  assign mem_rdata = mem_arr[mem_addr[7:0]];

  always @(posedge clk) begin
    ack_q <= mem_req && !ack_q;
    if (mem_req && mem_we && ack_q) mem_arr[mem_addr[7:0]] <= mem_wdata;
  end

  // port monitor
  always @(negedge clk) begin
    if (mem_req && mem_ack) begin
      if (mem_we) begin wb_cnt = wb_cnt + 1; wb_addr = mem_addr; wb_data = mem_wdata; end
      else        begin rd_cnt = rd_cnt + 1; rd_addr = mem_addr; end
    end
    if (tlb_we) begin
      if (tlb_cnt < 2) begin
        vpn_log[tlb_cnt] = tlb_vpn;
        ent_log[tlb_cnt] = tlb_entry;
        usr_log[tlb_cnt] = tlb_user;
      end
      tlb_cnt = tlb_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_log();
    rd_cnt = 0; wb_cnt = 0; tlb_cnt = 0;
    rd_addr = '0; wb_addr = '0; wb_data = '0;
  endtask

  task automatic wait_end(output bit got_done, output bit got_fault,
                          output logic [21:0] fw);
    int cyc = 0;
    while (!(done || fault) && cyc < 200) begin
      @(negedge clk);
      cyc++;
    end
    got_done = done; got_fault = fault; fw = fault_word;
    if (cyc >= 200) chk(1'b0, "R10 walk timeout", 64'(cyc), 64'd200);
    @(negedge clk);
    chk(!done && !fault, "R10 single-cycle pulse", {62'd0, done, fault}, 64'd0);
  endtask

  task automatic run_one(input logic [56:0] v, input logic inject_busy);
    logic [17:0] va;
    logic u, w, t, wr, right, cch, exp_fault;
    logic [35:0] word, exp_wb;
    logic [17:0] half;
    logic [1:0] code;
    logic [19:0] exp_addr;
    logic [9:0] lpn;
    logic [13:0] exp_e0, exp_e1;
    logic [21:0] exp_fw, fw;
    bit gd, gf;
    va = v[56:39]; u = v[38]; w = v[37]; t = v[36]; word = v[35:0];
    wr = w | t;
    // R1: base choice and index
    case ({u, va[17]})
      2'b10: exp_addr = B_UL;
      2'b11: exp_addr = B_UH;
      2'b00: exp_addr = B_EL;
      default: exp_addr = B_EH;
    endcase
    exp_addr = exp_addr + {14'd0, va[16:11]};
    // R2: halfword choice
    right = va[10];
    half = right ? word[17:0] : word[35:18];
    code = half[17:16]; cch = half[12]; lpn = half[9:0];
    exp_fault = (code == 2'd0) || (code != 2'd3 && wr);
    exp_wb = word;
    if (right) exp_wb[13] = 1'b0; else exp_wb[31] = 1'b0;
    exp_e0 = {1'b1, code == 2'd3, cch, lpn, 1'b0};
    exp_e1 = {1'b1, code == 2'd3, cch, lpn, 1'b1};
    exp_fw = {u, wr, (code == 2'd3) ? 2'd0 : code, va};

    mem_arr[exp_addr[7:0]] = word;
    clear_log();
    @(negedge clk);
    miss_va = va; miss_user = u; miss_write = w; miss_wtest = t; miss_valid = 1'b1;
    @(negedge clk);
    miss_valid = 1'b0;
    if (inject_busy) begin
      @(negedge clk);
      miss_va = ~va; miss_user = ~u; miss_write = 1'b0; miss_wtest = 1'b0;
      miss_valid = 1'b1;
      @(negedge clk);
      miss_valid = 1'b0;
    end
    wait_end(gd, gf, fw);

    chk(rd_cnt == 1 && rd_addr == exp_addr, "R1 R2 table read address",
        64'(rd_addr), 64'(exp_addr));
    chk(gf == exp_fault && gd == !exp_fault, "R3 R4 R5 R6 outcome",
        {62'd0, gd, gf}, {62'd0, !exp_fault, exp_fault});
    if (exp_fault) begin
      chk(fw == exp_fw, "R9 R6 R4 fault word", 64'(fw), 64'(exp_fw));
      chk(wb_cnt == 0 && tlb_cnt == 0, "R3 no write-back or entry on fault",
          64'(wb_cnt * 16 + tlb_cnt), 64'd0);
    end else begin
      chk(wb_cnt == 1 && wb_addr == exp_addr && wb_data == exp_wb,
          "R7 write-back word", 64'(wb_data), 64'(exp_wb));
      chk(tlb_cnt == 2, "R8 two translation writes", 64'(tlb_cnt), 64'd2);
      chk(vpn_log[0] == {va[17:10], 1'b0} && ent_log[0] == exp_e0 && usr_log[0] == u,
          "R8 R4 R5 even entry", {41'd0, vpn_log[0], ent_log[0]},
          {41'd0, va[17:10], 1'b0, exp_e0});
      chk(vpn_log[1] == {va[17:10], 1'b1} && ent_log[1] == exp_e1 && usr_log[1] == u,
          "R8 R4 R5 odd entry", {41'd0, vpn_log[1], ent_log[1]},
          {41'd0, va[17:10], 1'b1, exp_e1});
    end
  endtask

  // watchdog
  initial begin
    #1_500_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem_arr[i] = '0;
    clear_log();
    repeat (3) @(negedge clk);
    // reset state
    chk(!mem_req && !tlb_we && !done && !fault, "R10 R11 reset outputs",
        {60'd0, mem_req, tlb_we, done, fault}, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_req && !tlb_we && !done && !fault, "R10 R11 idle after reset",
        {60'd0, mem_req, tlb_we, done, fault}, 64'd0);

    // vector table
    for (int k = 0; k < 10; k++) run_one(VECS[k], 1'b0);

    // R10: miss raised during a walk is ignored
    run_one(VECS[0], 1'b1);
    clear_log();
    repeat (8) @(negedge clk);
    chk(rd_cnt == 0 && !mem_req, "R10 busy miss ignored", 64'(rd_cnt), 64'd0);

    // R7: age bit already clear in selected half, other half keeps its age bit
    run_one({{1'b1,6'd33,1'b1,10'h0}, 3'b000, {18'h3FFFF,18'h30FFF}}, 1'b0);
    // R6: write-test on read/write/first page faults with access 2
    run_one({{1'b1,6'd50,1'b1,10'h3}, 3'b101, {18'h00000,18'h23FFF}}, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule